// File: doc/BRIEF.md
# Oversampled Serial Frame Receiver

This block recovers asynchronous serial frames from a single input line. An oversampling strobe arrives sixteen times per bit period. A falling edge on the idle-high line is only a candidate start bit. The receiver confirms it by sampling again at the middle of the bit, then samples every later bit at its centre. The frame has five to eight data bits, least significant bit first. A parity bit may follow the data. The frame ends on its first stop bit.

When the first stop bit has been sampled, the assembled word moves into a single holding register. A ready flag is set and stays high until the consumer pulses a read strobe. Parity and framing status are held with the word. A second stop bit, if the sender adds one, is never checked. Dropping the enable abandons any frame in progress.

Top module: `uart_rx_capture`

## Requirements
- R1: After reset, `rx_ready`, `rx_data`, `parity_err` and `frame_err` are all zero.
- R2: A low level starts a frame only if it is still low at the eighth oversampling strobe after detection (mid start bit). A shorter low pulse returns the receiver to idle and sets no flag.
- R3: Data bits arrive least significant bit first. `data_len` selects the count: 00 gives 5 bits, 01 gives 6, 10 gives 7 and 11 gives 8. The stored word has every bit above the configured length at zero.
- R4: When `parity_en` is 1, one parity bit follows the last data bit. `parity_odd` = 0 selects even parity and 1 selects odd parity. `parity_err` is set when the received bit mismatches. It is 0 when parity is disabled.
- R5: `frame_err` is set when the first stop bit samples low. The word is still stored and `rx_ready` is still set.
- R6: The frame completes at the centre of its first stop bit. A new start bit may follow the first stop bit directly, and that frame is received correctly.
- R7: A one-cycle `rd_strobe` clears `rx_ready` and leaves `rx_data` and both error flags unchanged.
- R8: While `enable` is 0 the receiver stays idle. Dropping it mid-frame discards the frame, so `rx_ready` is not set by it.
- R9: After a framing error the receiver waits for the line to go high before it looks for a new start bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Receiver enable; low aborts and holds idle |
| os_tick | input | 1 | Oversampling strobe, 16 per bit period |
| rx_in | input | 1 | Asynchronous serial line, idle high |
| data_len | input | 2 | Data length code (5 + code bits) |
| parity_en | input | 1 | Parity bit present |
| parity_odd | input | 1 | 1 = odd parity, 0 = even parity |
| rd_strobe | input | 1 | Read pulse, clears the ready flag |
| rx_data | output | 8 | Received word, upper unused bits zero |
| rx_ready | output | 1 | Unread word present |
| parity_err | output | 1 | Parity mismatch on the stored word |
| frame_err | output | 1 | First stop bit sampled low |

## Verification
A line change reaches the state machine two clocks later through the synchronizer. A confirmed start is checked eight strobes after detection. Each later bit is sampled sixteen strobes after the one before. With the strobe held high, the word and flags therefore appear 27 clocks after the start of the first stop bit minus 16, which is 11 clocks into the stop bit. The bench drives each bit for a full 16 clocks and checks only after the whole stop bit, which leaves margin on both sides. A read clears the flag on the next edge, and the bench checks it one cycle later. Glitch and abort cases wait far longer than a frame before they confirm that nothing arrived.

// File: rtl/rxcap_pkg.sv
package rxcap_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP,
        ST_WAIT_HI
    } rx_state_e;
endpackage

// File: rtl/rxcap_sync.sv
module rxcap_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);
    logic [STAGES-1:0] chain_q;
    logic [STAGES-1:0] chain_d;

    always_comb begin
        chain_d = {chain_q[STAGES-2:0], async_in};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '1;
        else        chain_q <= chain_d;
    end

    assign sync_out = chain_q[STAGES-1];
endmodule

// File: rtl/rxcap_core.sv
module rxcap_core
    import rxcap_pkg::*;
#(
    parameter int OSR      = 16,
    parameter int MIN_BITS = 5,
    parameter int MAX_BITS = 8,
    parameter int LEN_W    = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                enable,
    input  logic                os_tick,
    input  logic                line_s,
    input  logic [LEN_W-1:0]    data_len,
    input  logic                parity_en,
    input  logic                parity_odd,
    input  logic                rd_strobe,
    output logic [MAX_BITS-1:0] word_o,
    output logic                ready_o,
    output logic                perr_o,
    output logic                ferr_o
);
    localparam int CNT_W = $clog2(OSR);
    localparam int IDX_W = $clog2(MAX_BITS);
    localparam logic [CNT_W-1:0] MID_CNT  = CNT_W'(OSR / 2 - 1);
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(OSR - 1);

    typedef struct packed {
        rx_state_e           state;
        logic [CNT_W-1:0]    tick_cnt;
        logic [IDX_W-1:0]    bit_idx;
        logic [MAX_BITS-1:0] shreg;
        logic                par_acc;
        logic                par_bad;
        logic [MAX_BITS-1:0] word;
        logic                perr;
        logic                ferr;
        logic                ready;
    } rx_regs_t;

    rx_regs_t r_q, r_d;
    logic [IDX_W-1:0] last_idx;
    logic             complete;

    assign last_idx = IDX_W'(MIN_BITS - 1) + IDX_W'(data_len);

    always_comb begin
        r_d      = r_q;
        complete = 1'b0;
        if (!enable) begin
            r_d.state    = ST_IDLE;
            r_d.tick_cnt = '0;
        end else if (os_tick) begin
            case (r_q.state)
                ST_IDLE: begin
                    if (!line_s) begin
                        r_d.state    = ST_START;
                        r_d.tick_cnt = '0;
                    end
                end
                ST_START: begin
                    if (r_q.tick_cnt == MID_CNT) begin
                        r_d.tick_cnt = '0;
                        if (!line_s) begin
                            r_d.state   = ST_DATA;
                            r_d.bit_idx = '0;
                            r_d.shreg   = '0;
                            r_d.par_acc = 1'b0;
                            r_d.par_bad = 1'b0;
                        end else begin
                            r_d.state = ST_IDLE;
                        end
                    end else begin
                        r_d.tick_cnt = r_q.tick_cnt + 1'b1;
                    end
                end
                ST_DATA: begin
                    if (r_q.tick_cnt == LAST_CNT) begin
                        r_d.tick_cnt              = '0;
                        r_d.shreg[r_q.bit_idx]    = line_s;
                        r_d.par_acc               = r_q.par_acc ^ line_s;
                        if (r_q.bit_idx == last_idx)
                            r_d.state = parity_en ? ST_PAR : ST_STOP;
                        else
                            r_d.bit_idx = r_q.bit_idx + 1'b1;
                    end else begin
                        r_d.tick_cnt = r_q.tick_cnt + 1'b1;
                    end
                end
                ST_PAR: begin
                    if (r_q.tick_cnt == LAST_CNT) begin
                        r_d.tick_cnt = '0;
                        r_d.par_bad  = line_s ^ r_q.par_acc ^ parity_odd;
                        r_d.state    = ST_STOP;
                    end else begin
                        r_d.tick_cnt = r_q.tick_cnt + 1'b1;
                    end
                end
                ST_STOP: begin
                    if (r_q.tick_cnt == LAST_CNT) begin
                        r_d.tick_cnt = '0;
                        r_d.word     = r_q.shreg;
                        r_d.perr     = r_q.par_bad;
                        r_d.ferr     = ~line_s;
                        r_d.ready    = 1'b1;
                        complete     = 1'b1;
                        r_d.state    = line_s ? ST_IDLE : ST_WAIT_HI;
                    end else begin
                        r_d.tick_cnt = r_q.tick_cnt + 1'b1;
                    end
                end
                ST_WAIT_HI: begin
                    if (line_s) r_d.state = ST_IDLE;
                end
                default: r_d.state = ST_IDLE;
            endcase
        end
        if (rd_strobe && !complete) r_d.ready = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{state: ST_IDLE, default: '0};
        else        r_q <= r_d;
    end

    assign word_o  = r_q.word;
    assign ready_o = r_q.ready;
    assign perr_o  = r_q.perr;
    assign ferr_o  = r_q.ferr;

    // R3: a freshly stored word carries nothing above the configured length
    a_r3_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready_o) |-> ((word_o >> (MIN_BITS + int'(data_len))) == '0));

    // R7: a read with no frame finishing clears the flag but keeps the word
    a_r7_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_strobe && !(os_tick && enable && r_q.state == ST_STOP && r_q.tick_cnt == LAST_CNT))
        |=> (!ready_o && $stable(word_o)));

    // R8: disabled receiver sits idle
    a_r8_disable_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (r_q.state == ST_IDLE));

    // R2: a high line never leaves idle
    a_r2_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_IDLE && line_s) |=> (r_q.state == ST_IDLE));

    // R9: a low stop bit leads to waiting for a high line
    a_r9_wait_high: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(ready_o) && ferr_o && enable) |-> (r_q.state == ST_WAIT_HI));

    // R4: no parity error can be reported when parity is off
    a_r4_no_par_err: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(ready_o) && !parity_en) |-> !perr_o);
endmodule

// File: rtl/uart_rx_capture.sv
module uart_rx_capture #(
    parameter int OSR       = 16,
    parameter int MIN_BITS  = 5,
    parameter int MAX_BITS  = 8,
    parameter int SYNC_LEN  = 2,
    localparam int LEN_W    = $clog2(MAX_BITS - MIN_BITS + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                enable,
    input  logic                os_tick,
    input  logic                rx_in,
    input  logic [LEN_W-1:0]    data_len,
    input  logic                parity_en,
    input  logic                parity_odd,
    input  logic                rd_strobe,
    output logic [MAX_BITS-1:0] rx_data,
    output logic                rx_ready,
    output logic                parity_err,
    output logic                frame_err
);
    logic line_s;

    rxcap_sync #(.STAGES(SYNC_LEN)) sync_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (rx_in),
        .sync_out (line_s)
    );

    rxcap_core #(
        .OSR      (OSR),
        .MIN_BITS (MIN_BITS),
        .MAX_BITS (MAX_BITS),
        .LEN_W    (LEN_W)
    ) core_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (enable),
        .os_tick    (os_tick),
        .line_s     (line_s),
        .data_len   (data_len),
        .parity_en  (parity_en),
        .parity_odd (parity_odd),
        .rd_strobe  (rd_strobe),
        .word_o     (rx_data),
        .ready_o    (rx_ready),
        .perr_o     (parity_err),
        .ferr_o     (frame_err)
    );
endmodule

// File: tb/uart_rx_capture_tb_top.sv
module uart_rx_capture_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       enable = 1'b0;
    logic       os_tick = 1'b1;
    logic       rx_in = 1'b1;
    logic [1:0] data_len = 2'b11;
    logic       parity_en = 1'b0;
    logic       parity_odd = 1'b0;
    logic       rd_strobe = 1'b0;
    logic [7:0] rx_data;
    logic       rx_ready, parity_err, frame_err;

    int n_tests = 0;
    int n_fail  = 0;

    always #2 clk = ~clk;

    uart_rx_capture dut_i (
        .clk(clk), .rst_n(rst_n), .enable(enable), .os_tick(os_tick),
        .rx_in(rx_in), .data_len(data_len), .parity_en(parity_en),
        .parity_odd(parity_odd), .rd_strobe(rd_strobe),
        .rx_data(rx_data), .rx_ready(rx_ready),
        .parity_err(parity_err), .frame_err(frame_err)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic drive_bit(input logic b, input bit rd_first);
        rx_in = b;
        if (rd_first) begin
            rd_strobe = 1'b1;
            @(negedge clk);
            rd_strobe = 1'b0;
            wait_cyc(15);
        end else begin
            wait_cyc(16);
        end
    endtask

    task automatic send_frame(input logic [7:0] d, input int len, input bit pen, input bit podd,
                              input bit bad_par, input bit bad_stop, input bit rd_first);
        logic [7:0] m;
        logic       pb;
        m          = d & 8'((1 << len) - 1);
        data_len   = 2'(len - 5);
        parity_en  = pen;
        parity_odd = podd;
        pb         = (^m) ^ podd ^ bad_par;
        drive_bit(1'b0, rd_first);
        for (int i = 0; i < len; i++) drive_bit(d[i], 1'b0);
        if (pen) drive_bit(pb, 1'b0);
        drive_bit(~bad_stop, 1'b0);
        rx_in = 1'b1;
    endtask

    task automatic do_read();
        rd_strobe = 1'b1;
        @(negedge clk);
        rd_strobe = 1'b0;
        @(negedge clk);
    endtask

    task automatic check_word(input string req, input logic [7:0] d, input int len,
                              input bit pe, input bit fe);
        chk({req, " ready"}, 32'(rx_ready), 32'd1);
        chk({req, " data"}, 32'(rx_data), 32'(d & 8'((1 << len) - 1)));
        chk({req, " perr"}, 32'(parity_err), 32'(pe));
        chk({req, " ferr"}, 32'(frame_err), 32'(fe));
    endtask

    task automatic t_reset();
        chk("R1 ready", 32'(rx_ready), 0);
        chk("R1 data", 32'(rx_data), 0);
        chk("R1 perr", 32'(parity_err), 0);
        chk("R1 ferr", 32'(frame_err), 0);
    endtask

    task automatic t_lengths();
        logic [7:0] pats [4] = '{8'hA5, 8'hFF, 8'h3C, 8'hC9};
        for (int len = 5; len <= 8; len++) begin
            send_frame(pats[len-5], len, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
            check_word("R3 length", pats[len-5], len, 1'b0, 1'b0);
            do_read();
            wait_cyc(5);
        end
    endtask

    task automatic t_parity();
        send_frame(8'h5B, 8, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
        check_word("R4 even ok", 8'h5B, 8, 1'b0, 1'b0);
        do_read();
        send_frame(8'h17, 6, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
        check_word("R4 odd ok", 8'h17, 6, 1'b0, 1'b0);
        do_read();
        send_frame(8'h6E, 7, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0);
        check_word("R4 even bad", 8'h6E, 7, 1'b1, 1'b0);
        do_read();
        send_frame(8'h12, 5, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0);
        check_word("R4 odd bad", 8'h12, 5, 1'b1, 1'b0);
        do_read();
        wait_cyc(5);
    endtask

    task automatic t_read();
        send_frame(8'h81, 8, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0);
        do_read();
        chk("R7 ready cleared", 32'(rx_ready), 0);
        chk("R7 data kept", 32'(rx_data), 32'h81);
        chk("R7 perr kept", 32'(parity_err), 1);
    endtask

    task automatic t_frame_err();
        send_frame(8'h44, 8, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
        check_word("R5 bad stop", 8'h44, 8, 1'b0, 1'b1);
        do_read();
        wait_cyc(5);
        send_frame(8'h99, 8, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        check_word("R9 after break", 8'h99, 8, 1'b0, 1'b0);
        do_read();
    endtask

    task automatic t_break_hold();
        rx_in = 1'b0;
        wait_cyc(16 * 12);
        chk("R5 long low ready", 32'(rx_ready), 1);
        chk("R5 long low ferr", 32'(frame_err), 1);
        chk("R5 long low data", 32'(rx_data), 0);
        do_read();
        wait_cyc(16 * 20);
        chk("R9 no refire while low", 32'(rx_ready), 0);
        rx_in = 1'b1;
        wait_cyc(10);
        send_frame(8'h3A, 8, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        check_word("R9 resume", 8'h3A, 8, 1'b0, 1'b0);
        do_read();
    endtask

    task automatic t_back_to_back();
        send_frame(8'hD2, 8, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        check_word("R6 first", 8'hD2, 8, 1'b0, 1'b0);
        send_frame(8'h2D, 8, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
        check_word("R6 second", 8'h2D, 8, 1'b0, 1'b0);
        do_read();
        wait_cyc(5);
    endtask

    task automatic t_glitch();
        rx_in = 1'b0;
        wait_cyc(4);
        rx_in = 1'b1;
        wait_cyc(16 * 12);
        chk("R2 glitch ignored", 32'(rx_ready), 0);
        send_frame(8'hE7, 8, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        check_word("R2 after glitch", 8'hE7, 8, 1'b0, 1'b0);
        do_read();
    endtask

    task automatic t_abort();
        data_len  = 2'b11;
        parity_en = 1'b0;
        drive_bit(1'b0, 1'b0);
        drive_bit(1'b1, 1'b0);
        drive_bit(1'b0, 1'b0);
        enable = 1'b0;
        rx_in  = 1'b1;
        wait_cyc(8);
        enable = 1'b1;
        wait_cyc(16 * 12);
        chk("R8 aborted frame", 32'(rx_ready), 0);
        enable = 1'b0;
        rx_in  = 1'b0;
        wait_cyc(16 * 12);
        rx_in  = 1'b1;
        wait_cyc(4);
        chk("R8 disabled ignores line", 32'(rx_ready), 0);
        enable = 1'b1;
        wait_cyc(4);
        send_frame(8'h5A, 8, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        check_word("R8 after re-enable", 8'h5A, 8, 1'b0, 1'b0);
        do_read();
    endtask

    initial begin
        wait_cyc(4);
        t_reset();
        rst_n = 1'b1;
        wait_cyc(2);
        enable = 1'b1;
        wait_cyc(4);
        t_lengths();
        t_parity();
        t_read();
        t_frame_err();
        t_break_hold();
        t_back_to_back();
        t_glitch();
        t_abort();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule